// File: doc/BRIEF.md
# Banked Gamma Lookup Engine

This block applies a per-channel gamma curve to a stream of RGB pixels. Each 12-bit colour component selects an entry from its own table by its most significant bits, and the table value replaces the component. Pixels arrive and leave with valid/ready handshaking, one pixel per cycle. A lookup takes two cycles from acceptance to output.

The tables are loaded over a simple byte-addressed register bus. A bank register selects which slice of the tables the two write windows reach. It also chooses how each window word is packed. In narrow mode, one word carries all three components at 10 bits. In wide mode, red and green share a word in the first window and blue has its own word in the second. The engine can be built to store odd entries as deltas from their even neighbour, and it rebuilds the full value on every read. A relay bit, or a cleared table-enable bit, sends pixels through untouched with the same latency. A global enable bit gates acceptance of new pixels.

Top module: `gamma_lut_engine`

## Requirements
- R1: After reset, every control register reads 0, `in_ready` is low and `out_valid` is low.
- R2: Bit 0 at byte address 0x000 is the block enable. While it is 0, `in_ready` stays low and no pixel is taken in. Writing 0 stops acceptance. Pixels already inside still drain.
- R3: The register at 0x020 holds three bits: bit 0 relay, bit 1 table enable, and bit 2 a descending-curve flag, which is stored and read back but does not alter the data path. Reads return bits 2:0 with all other bits 0.
- R4: The register at 0x030 stores a 13-bit width from write bits 28:16 and a 13-bit height from write bits 12:0. It reads back at the same positions with all other bits 0.
- R5: The register at 0x100 holds a bank number in bits 1:0 and a wide-mode flag in bit 2, and reads back bits 2:0. Window writes are dropped while the bank number is NUM_BANKS or more.
- R6: In narrow mode, a write to word i of the window at 0x700 sets red from bits 29:20, green from bits 19:10 and blue from bits 9:0. Each value is stored as value*4 in a 12-bit entry. Writes to the window at 0xB00 are ignored in narrow mode.
- R7: In wide mode, a write to the 0x700 window sets red from bits 11:0 and green from bits 23:12 and leaves blue unchanged. A write to the 0xB00 window sets only blue from bits 11:0.
- R8: A component's table index is its top IDX_W bits, where IDX_W = log2(BANK_ENTRIES*NUM_BANKS). With `out_ready` high and the pipeline empty, `out_valid` rises exactly two clock edges after the acceptance edge.
- R9: With DIFF_MODE=1, reading an odd index returns (stored even entry + stored odd entry) mod 4096, and reading an even index returns the stored value. With DIFF_MODE=0, every index returns its stored value.
- R10: When relay is 1 or table enable is 0 at the acceptance edge, the output pixel equals the input pixel, with the same two-cycle latency.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pix` hold steady. Pixels leave in acceptance order, with none lost or repeated.
- R12: Word i of a window in bank b updates table entry b*BANK_ENTRIES + i, so every bank reaches a distinct slice of the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Engine accepts a pixel this cycle |
| in_pix | input | 36 | Input pixel: red 35:24, green 23:12, blue 11:0 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | 36 | Output pixel, same packing as `in_pix` |

## Verification
An output stall can coincide with the arrival of a new pixel. The second pipeline stage must then hold its word while the first stage keeps its own, and one cycle later both must move together. The bench provokes this by streaming a full table sweep while `out_ready` follows a pseudo-random sequence, so stalls begin and end with the input kept busy. A monitor judges the result in two ways. It checks that every stalled output is still present and unchanged at the next sample. It also checks that each delivered pixel matches the next entry of an expected-value queue filled at the acceptance edges.

// File: rtl/glut_pkg.sv
package glut_pkg;
   localparam int ENTRY_W  = 12;
   localparam int NARROW_W = 10;
   localparam int ADDR_W   = 12;
   localparam int PIX_W    = 3 * ENTRY_W;

   localparam logic [ADDR_W-1:0] A_ENABLE = 12'h000;
   localparam logic [ADDR_W-1:0] A_CFG    = 12'h020;
   localparam logic [ADDR_W-1:0] A_SIZE   = 12'h030;
   localparam logic [ADDR_W-1:0] A_BANK   = 12'h100;
   localparam logic [ADDR_W-1:0] A_WIN0   = 12'h700;
   localparam logic [ADDR_W-1:0] A_WIN1   = 12'hB00;

   typedef struct packed {
      logic desc;
      logic lut_on;
      logic relay;
   } cfg_t;

   function automatic logic [ENTRY_W-1:0] widen(input logic [NARROW_W-1:0] v);
      return {v, {(ENTRY_W - NARROW_W){1'b0}}};
   endfunction
endpackage

// File: rtl/glut_regs.sv
module glut_regs
   import glut_pkg::*;
#(
   parameter int BANK_ENTRIES = 64,
   parameter int NUM_BANKS    = 4,
   localparam int WORD_W      = $clog2(BANK_ENTRIES),
   localparam int IDX_W       = WORD_W + $clog2(NUM_BANKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   output logic                  blk_on,
   output cfg_t                  cfg,
   output logic [2:0]            wr_ch,
   output logic [IDX_W-1:0]      wr_idx,
   output logic [PIX_W-1:0]      wr_word
);
   localparam int WIN_BYTES = 4 * BANK_ENTRIES;
   localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   if ((1 << WORD_W) != BANK_ENTRIES || BANK_ENTRIES < 2 || BANK_ENTRIES > 256)
      $error("BANK_ENTRIES must be a power of two from 2 to 256");
   if ((1 << $clog2(NUM_BANKS)) != NUM_BANKS || NUM_BANKS > 4)
      $error("NUM_BANKS must be 1, 2 or 4");

   logic        en_q;
   cfg_t        cfg_q;
   logic [12:0] hsz_q, vsz_q;
   logic [1:0]  bank_q;
   logic        wide_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         cfg_q  <= '0;
         hsz_q  <= '0;
         vsz_q  <= '0;
         bank_q <= '0;
         wide_q <= 1'b0;
      end else if (reg_wr) begin
         unique case (reg_addr)
            A_ENABLE: en_q  <= reg_wdata[0];
            A_CFG:    cfg_q <= cfg_t'(reg_wdata[2:0]);
            A_SIZE: begin
               hsz_q <= reg_wdata[28:16];
               vsz_q <= reg_wdata[12:0];
            end
            A_BANK: begin
               bank_q <= reg_wdata[1:0];
               wide_q <= reg_wdata[2];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (reg_addr)
         A_ENABLE: reg_rdata = {31'b0, en_q};
         A_CFG:    reg_rdata = {29'b0, cfg_q};
         A_SIZE:   reg_rdata = {3'b0, hsz_q, 3'b0, vsz_q};
         A_BANK:   reg_rdata = {29'b0, wide_q, bank_q};
         default:  reg_rdata = '0;
      endcase
   end

   assign blk_on = en_q;
   assign cfg    = cfg_q;

   // window decode
   logic              in_win0, in_win1, bank_ok;
   logic [ADDR_W-1:0] off0, off1;
   logic [WORD_W-1:0] word_sel;

   assign in_win0  = (int'(reg_addr) >= int'(A_WIN0)) && (int'(reg_addr) < int'(A_WIN0) + WIN_BYTES);
   assign in_win1  = (int'(reg_addr) >= int'(A_WIN1)) && (int'(reg_addr) < int'(A_WIN1) + WIN_BYTES);
   assign bank_ok  = 32'(bank_q) < NUM_BANKS;
   assign off0     = reg_addr - A_WIN0;
   assign off1     = reg_addr - A_WIN1;
   assign word_sel = in_win1 ? off1[WORD_W+1:2] : off0[WORD_W+1:2];

   if (NUM_BANKS > 1) begin : g_banked
      assign wr_idx = {bank_q[BSEL_W-1:0], word_sel};
   end else begin : g_flat
      assign wr_idx = word_sel;
   end

   always_comb begin
      wr_ch   = 3'b000;
      wr_word = '0;
      if (reg_wr && bank_ok) begin
         if (wide_q) begin
            if (in_win0) begin
               wr_ch[2]     = 1'b1;
               wr_ch[1]     = 1'b1;
               wr_word[35:24] = reg_wdata[11:0];
               wr_word[23:12] = reg_wdata[23:12];
            end else if (in_win1) begin
               wr_ch[0]     = 1'b1;
               wr_word[11:0] = reg_wdata[11:0];
            end
         end else if (in_win0) begin
            wr_ch   = 3'b111;
            wr_word = {widen(reg_wdata[29:20]), widen(reg_wdata[19:10]), widen(reg_wdata[9:0])};
         end
      end
   end

   logic unused_bits;
   assign unused_bits = ^{reg_wdata[31:30], off0, off1};

   assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_ENABLE) |=> (blk_on == $past(reg_wdata[0])));

   assert_size_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_SIZE) |=> (hsz_q == $past(reg_wdata[28:16]) && vsz_q == $past(reg_wdata[12:0])));

   assert_bank_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_BANK) |=> ({wide_q, bank_q} == $past(reg_wdata[2:0])));

   assert_narrow_win1_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide_q && !in_win0) |-> (wr_ch == 3'b000));
endmodule

// File: rtl/glut_chan.sv
module glut_chan
   import glut_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter bit DIFF_MODE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_val,
   input  logic               rd_en,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [ENTRY_W-1:0] rd_val
);
   localparam int PAIRS = 1 << (IDX_W - 1);

   logic [ENTRY_W-1:0] even_mem [PAIRS];
   logic [ENTRY_W-1:0] odd_mem  [PAIRS];
   logic [ENTRY_W-1:0] s1_even, s1_oddv;
   logic               s1_sel;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         if (wr_idx[0]) odd_mem[wr_idx[IDX_W-1:1]]  <= wr_val;
         else           even_mem[wr_idx[IDX_W-1:1]] <= wr_val;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en) begin
         s1_even <= even_mem[rd_idx[IDX_W-1:1]];
         s1_oddv <= odd_mem[rd_idx[IDX_W-1:1]];
         s1_sel  <= rd_idx[0];
      end
   end

   if (DIFF_MODE) begin : g_delta
      assign rd_val = s1_sel ? (s1_even + s1_oddv) : s1_even;
   end else begin : g_absolute
      assign rd_val = s1_sel ? s1_oddv : s1_even;
   end

   assert_even_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_idx[0]) |=> (even_mem[$past(wr_idx[IDX_W-1:1])] == $past(wr_val)));

   assert_odd_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx[0]) |=> (odd_mem[$past(wr_idx[IDX_W-1:1])] == $past(wr_val)));
endmodule

// File: rtl/gamma_lut_engine.sv
module gamma_lut_engine
   import glut_pkg::*;
#(
   parameter int BANK_ENTRIES = 64,
   parameter int NUM_BANKS    = 4,
   parameter bit DIFF_MODE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [35:0]       in_pix,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [35:0]       out_pix
);
   localparam int IDX_W = $clog2(BANK_ENTRIES) + $clog2(NUM_BANKS);

   if (IDX_W > ENTRY_W || IDX_W < 2)
      $error("table index width must lie between 2 and the component width");

   logic               blk_on;
   cfg_t               cfg;
   logic [2:0]         wr_ch;
   logic [IDX_W-1:0]   wr_idx;
   logic [PIX_W-1:0]   wr_word;
   logic [PIX_W-1:0]   lut_pix;

   glut_regs #(
      .BANK_ENTRIES (BANK_ENTRIES),
      .NUM_BANKS    (NUM_BANKS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .blk_on    (blk_on),
      .cfg       (cfg),
      .wr_ch     (wr_ch),
      .wr_idx    (wr_idx),
      .wr_word   (wr_word)
   );

   // pipeline control
   logic             adv, fire;
   logic             s1_v, s1_byp;
   logic [PIX_W-1:0] s1_pix;

   assign adv      = !out_valid || out_ready;
   assign in_ready = blk_on && adv;
   assign fire     = in_valid && in_ready;

   for (genvar c = 0; c < 3; c++) begin : g_chan
      glut_chan #(
         .IDX_W     (IDX_W),
         .DIFF_MODE (DIFF_MODE)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_ch[c]),
         .wr_idx (wr_idx),
         .wr_val (wr_word[c*ENTRY_W +: ENTRY_W]),
         .rd_en  (adv),
         .rd_idx (in_pix[c*ENTRY_W + ENTRY_W - IDX_W +: IDX_W]),
         .rd_val (lut_pix[c*ENTRY_W +: ENTRY_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v      <= 1'b0;
         s1_byp    <= 1'b0;
         s1_pix    <= '0;
         out_valid <= 1'b0;
         out_pix   <= '0;
      end else if (adv) begin
         s1_v      <= fire;
         s1_byp    <= cfg.relay || !cfg.lut_on;
         s1_pix    <= in_pix;
         out_valid <= s1_v;
         out_pix   <= s1_byp ? s1_pix : lut_pix;
      end
   end

   assert_stage_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_v && adv) |=> out_valid);

   assert_output_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

   assert_bypass_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && s1_v && s1_byp) |=> (out_pix == $past(s1_pix)));

   assert_no_accept_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_on && !$past(s1_v) && !$past(out_valid) && !s1_v) |=> !out_valid);
endmodule

// File: tb/gamma_lut_engine_bench.sv
module gamma_lut_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 256;
   localparam int QN         = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata, reg_rdata_a;
   logic        in_valid = 1'b0;
   logic [35:0] in_pix = '0;
   logic        in_ready, in_ready_a;
   logic        out_valid, out_valid_a;
   logic        out_ready = 1'b1;
   logic [35:0] out_pix, out_pix_a;

   always #(CLK_PERIOD/2) clk = ~clk;

   gamma_lut_engine #(.BANK_ENTRIES(64), .NUM_BANKS(4), .DIFF_MODE(1'b1)) u_gamma_lut_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
      .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix));

   gamma_lut_engine #(.BANK_ENTRIES(64), .NUM_BANKS(4), .DIFF_MODE(1'b0)) u_gamma_lut_engine_abs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata_a), .in_valid(in_valid), .in_ready(in_ready_a), .in_pix(in_pix),
      .out_valid(out_valid_a), .out_ready(out_ready), .out_pix(out_pix_a));

   int n_chk = 0;
   int n_fail = 0;
   int mdl [3][DEPTH];          // channel 0 blue, 1 green, 2 red
   logic [35:0] q_d [QN];
   logic [35:0] q_a [QN];
   int q_head = 0;
   int q_tail = 0;
   bit rdy_rand = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   bit cur_lut = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(reg_rdata == exp, req, {4'b0, reg_rdata}, {4'b0, exp});
   endtask

   function automatic int look(input int c, input int idx, input bit dif);
      if (dif && idx[0]) return (mdl[c][idx-1] + mdl[c][idx]) & 4095;
      return mdl[c][idx];
   endfunction

   // send one pixel whose channels use table indices ri, gi, bi
   task automatic send(input int ri, input int gi, input int bi);
      int ix [3];
      logic [35:0] p, ed, ea;
      ix[0] = bi; ix[1] = gi; ix[2] = ri;
      for (int c = 0; c < 3; c++) begin
         p[c*12 +: 12]  = 12'((ix[c] << 4) | ((ix[c] * 3 + c) & 15));
         ed[c*12 +: 12] = cur_lut ? 12'(look(c, ix[c], 1'b1)) : p[c*12 +: 12];
         ea[c*12 +: 12] = cur_lut ? 12'(look(c, ix[c], 1'b0)) : p[c*12 +: 12];
      end
      @(negedge clk);
      in_valid = 1'b1; in_pix = p;
      #2;
      while (!in_ready) begin
         @(negedge clk);
         #2;
      end
      q_d[q_tail % QN] = ed;
      q_a[q_tail % QN] = ea;
      q_tail++;
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      int lim = 0;
      idle();
      while (q_head != q_tail && lim < 5000) begin
         @(negedge clk);
         lim++;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic sweep();
      for (int k = 0; k < DEPTH; k++) send(k, (k + 85) % DEPTH, (k * 3 + 7) % DEPTH);
      drain();
   endtask

   // output ready pattern
   initial forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = rdy_rand ? (lfsr[0] | lfsr[5]) : 1'b1;
   end

   // output monitor: ordering, values, hold under stall (R11)
   bit stalled = 1'b0;
   logic [35:0] held = '0;
   initial forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
         if (stalled)
            chk(out_valid && out_pix == held, "R11 stalled output changed", out_pix, held);
         stalled = out_valid && !out_ready;
         held = out_pix;
         if (out_valid && out_ready) begin
            if (q_head == q_tail) begin
               chk(1'b0, "R11 unexpected output", out_pix, '0);
            end else begin
               chk(out_pix == q_d[q_head % QN], "R9 R8 delta-table output", out_pix, q_d[q_head % QN]);
               chk(out_valid_a && out_pix_a == q_a[q_head % QN], "R9 absolute-table output", out_pix_a, q_a[q_head % QN]);
               q_head++;
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R8 watchdog expired", '0, 36'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int r10, g10, b10, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #1;
      chk(!in_ready && !out_valid, "R1 handshake after reset", {34'b0, in_ready, out_valid}, '0);
      rd_chk(12'h000, 32'h0, "R1 enable");
      rd_chk(12'h020, 32'h0, "R1 config");
      rd_chk(12'h030, 32'h0, "R1 size");
      rd_chk(12'h100, 32'h0, "R1 bank");

      // R4 size register
      wr(12'h030, 32'hFFFF_FFFF);
      rd_chk(12'h030, 32'h1FFF_1FFF, "R4 size field masks");
      wr(12'h030, (32'd1920 << 16) | 32'd1080);
      rd_chk(12'h030, (32'd1920 << 16) | 32'd1080, "R4 size value");
      // R3 config register
      wr(12'h020, 32'h7);
      rd_chk(12'h020, 32'h7, "R3 config bits");
      wr(12'h020, 32'hFFFF_FFF8);
      rd_chk(12'h020, 32'h0, "R3 config other bits");
      // R5 bank register
      wr(12'h100, 32'hFF);
      rd_chk(12'h100, 32'h7, "R5 bank readback");

      // R6 R12 narrow-mode load, all banks
      for (int b = 0; b < 4; b++) begin
         wr(12'h100, 32'(b));
         for (int i = 0; i < 64; i++) begin
            n = b * 64 + i;
            r10 = (n * 7 + 3) & 1023;
            g10 = (n * 13 + 100) & 1023;
            b10 = (n * 29 + 5) & 1023;
            wr(12'(12'h700 + 4 * i), 32'((r10 << 20) | (g10 << 10) | b10));
            mdl[2][n] = r10 << 2; mdl[1][n] = g10 << 2; mdl[0][n] = b10 << 2;
         end
      end
      // R6 second window ignored in narrow mode (bank still 3)
      for (int i = 0; i < 64; i++) wr(12'(12'hB00 + 4 * i), 32'hFFF);

      // R2 disabled: no acceptance
      @(negedge clk);
      in_valid = 1'b1; in_pix = 36'h123456789;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         #2;
         chk(!in_ready && !out_valid, "R2 disabled block accepted", {34'b0, in_ready, out_valid}, '0);
      end
      idle();

      wr(12'h000, 32'h1);
      wr(12'h020, 32'h2);
      cur_lut = 1'b1;
      // R8 latency: two edges from acceptance
      @(negedge clk);
      in_valid = 1'b1; in_pix = {12'h050, 12'h0A0, 12'h0F0};
      q_d[q_tail % QN] = {12'(look(2, 5, 1)), 12'(look(1, 10, 1)), 12'(look(0, 15, 1))};
      q_a[q_tail % QN] = {12'(look(2, 5, 0)), 12'(look(1, 10, 0)), 12'(look(0, 15, 0))};
      q_tail++;
      #2;
      chk(in_ready, "R8 ready when enabled", {35'b0, in_ready}, 36'd1);
      @(negedge clk);
      in_valid = 1'b0;
      #2;
      chk(!out_valid, "R8 output one edge after accept", {35'b0, out_valid}, '0);
      @(negedge clk);
      #2;
      chk(out_valid, "R8 output two edges after accept", {35'b0, out_valid}, 36'd1);
      drain();

      // R6 R9 R12 narrow-mode sweep
      sweep();

      // R7 R12 wide-mode load
      for (int b = 0; b < 4; b++) begin
         wr(12'h100, 32'h4 | 32'(b));
         for (int i = 0; i < 64; i++) begin
            n = b * 64 + i;
            mdl[2][n] = (n * 37 + 11) & 4095;
            mdl[1][n] = (n * 91 + 2000) & 4095;
            wr(12'(12'h700 + 4 * i), 32'((mdl[1][n] << 12) | mdl[2][n]));
         end
         for (int i = 0; i < 64; i++) begin
            n = b * 64 + i;
            mdl[0][n] = (n * 53 + 700) & 4095;
            wr(12'(12'hB00 + 4 * i), 32'hFFFF_F000 | 32'(mdl[0][n]));
         end
      end
      // R7 a blue-only write leaves red and green
      wr(12'hB14, 32'h0000_0ABC);
      mdl[0][3 * 64 + 5] = 12'hABC;
      // R5 bank beyond range not relevant for 4 banks; R11 with random backpressure
      rdy_rand = 1'b1;
      sweep();
      rdy_rand = 1'b0;

      // R9 wrap of delta sum, bank 0 entries 0 and 1
      wr(12'h100, 32'h4);
      wr(12'h700, 32'h0080_0FFF); mdl[2][0] = 12'hFFF; mdl[1][0] = 12'h800;
      wr(12'h704, 32'h0080_0002); mdl[2][1] = 12'h002; mdl[1][1] = 12'h800;
      wr(12'hB00, 32'h0000_0FFF); mdl[0][0] = 12'hFFF;
      wr(12'hB04, 32'h0000_0001); mdl[0][1] = 12'h001;
      send(1, 1, 1);
      send(0, 0, 0);
      drain();

      // R3 descending flag has no data-path effect
      wr(12'h020, 32'h6);
      for (int k = 0; k < 32; k++) send(k * 8 + 1, k * 8 + 3, k * 8 + 6);
      drain();

      // R10 relay and table-off pass-through
      cur_lut = 1'b0;
      wr(12'h020, 32'h3);
      for (int k = 0; k < 64; k++) send(k * 4, (k * 4 + 1) % DEPTH, (k * 4 + 2) % DEPTH);
      drain();
      wr(12'h020, 32'h0);
      rdy_rand = 1'b1;
      for (int k = 0; k < 64; k++) send(k * 4 + 3, k, 255 - k);
      drain();
      rdy_rand = 1'b0;

      // R2 writing zero stops acceptance
      wr(12'h000, 32'h0);
      @(negedge clk);
      in_valid = 1'b1;
      #2;
      chk(!in_ready, "R2 stop after enable cleared", {35'b0, in_ready}, '0);
      idle();
      rd_chk(12'h000, 32'h0, "R2 enable readback");

      chk(q_head == q_tail, "R11 all pixels delivered", 36'(q_head), 36'(q_tail));
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule